// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block turns a 32.768 kHz time base into the periodic interrupt of a real-time clock. The time base arrives as a one-cycle enable pulse in the system clock domain. A three-bit reference-select field and a four-bit rate code choose the period. Each time a period ends, the block sets a periodic flag and an interrupt-request flag. The interrupt line follows the request flag, but only while the enable bit is high. A read strobe for the status register clears both flags.

A small state machine runs the period counter. It has three states. `ST_IDLE` holds the counter cleared while the configuration cannot run. `ST_LOAD` zeroes the counter for one cycle after any configuration change. `ST_COUNT` advances the counter on each time-base pulse.

Its transitions are:
- IDLE→LOAD when the configuration becomes runnable.
- LOAD→COUNT on the next cycle.
- COUNT→LOAD when the rate code, the reference select or the enable bit changes.
- LOAD→IDLE or COUNT→IDLE when the configuration stops being runnable.

In any other case a state stays where it is.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, `pf_flag`, `irqf_flag` and `irq` are all low.
- R2: With a valid reference and rate code c in 1..15, a period lasts 2^(c-1) pulses of `tick_32k`. The valid reference values are 3'b000, 3'b001 and 3'b010.
- R3: When `div_sel` is 3'b010, rate codes 1 and 2 give the periods of codes 8 and 9 (128 and 256 pulses). Codes 3..15 are not remapped.
- R4: A rate code of 0 produces no period expiry.
- R5: Any `div_sel` value other than 3'b000, 3'b001 or 3'b010 stops and clears the counter. After a valid value returns, a full period is counted from zero.
- R6: Each period expiry sets both `pf_flag` and `irqf_flag`.
- R7: `irq` is high only while `pie` is high. With `pie` low, an expiry still sets the flags but leaves `irq` low.
- R8: If `irqf_flag` is already set when `pie` rises, `irq` rises in that same cycle.
- R9: Any change of `pie`, in either direction, restarts the period count from zero.
- R10: Any change of `rate_sel` reloads the counter, so the next expiry comes one full new period after the change.
- R11: A `rd_c` pulse clears `pf_flag` and `irqf_flag`, and so drops `irq`, on the next cycle. If an expiry falls in the same cycle, the flags stay set.
- R12: The counter advances only in cycles where `tick_32k` is high; a flag can rise only after such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle pulse at 32.768 kHz |
| div_sel | input | 3 | Reference select field |
| rate_sel | input | 4 | Rate code |
| pie | input | 1 | Periodic interrupt enable |
| rd_c | input | 1 | Status register read strobe |
| pf_flag | output | 1 | Periodic flag |
| irqf_flag | output | 1 | Interrupt-request flag |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situation to reach from the ports is a reload or clear in the middle of a period: the counter state itself cannot be seen. The stimulus first feeds part of a period. It then changes the rate, toggles the enable, or steps the reference to an invalid value and back. After that it counts pulses until the flag rises. A total equal to a fresh full period shows that the counter restarted from zero. The two remapped codes need 128 and 256 pulses, so their periods are measured the same way.

// File: rtl/rpi_pkg.sv
package rpi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } pst_t;

    localparam int DIV_W = 3;
    localparam logic [DIV_W-1:0] REF_4M  = 3'b000;
    localparam logic [DIV_W-1:0] REF_1M  = 3'b001;
    localparam logic [DIV_W-1:0] REF_32K = 3'b010;
endpackage

// File: rtl/rpi_rate_decode.sv
module rpi_rate_decode
    import rpi_pkg::*;
#(
    parameter int RATE_W = 4,
    parameter int CNT_W  = (2 ** RATE_W) - 1
) (
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              run_ok,
    output logic [CNT_W-1:0]  last_cnt
);
    localparam logic [RATE_W-1:0] REMAP_ADD = RATE_W'(7);
    localparam logic [RATE_W-1:0] REMAP_MAX = RATE_W'(2);

    logic              ref_ok;
    logic [RATE_W-1:0] eff_code;

    always_comb begin
        ref_ok   = (div_sel == REF_4M) || (div_sel == REF_1M) || (div_sel == REF_32K);
        eff_code = rate_sel;
        // slow reference stretches the two fastest codes
        if ((div_sel == REF_32K) && (rate_sel != '0) && (rate_sel <= REMAP_MAX))
            eff_code = rate_sel + REMAP_ADD;
        run_ok   = ref_ok && (rate_sel != '0);
        if (run_ok)
            last_cnt = (CNT_W'(1) << (eff_code - RATE_W'(1))) - CNT_W'(1);
        else
            last_cnt = '0;
    end
endmodule

// File: rtl/rpi_period_ctr.sv
module rpi_period_ctr
    import rpi_pkg::*;
#(
    parameter int RATE_W = 4,
    parameter int CNT_W  = (2 ** RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie,
    input  logic              run_ok,
    input  logic [CNT_W-1:0]  last_cnt,
    output logic              expire
);
    pst_t              state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [RATE_W-1:0] rate_q;
    logic [DIV_W-1:0]  div_q;
    logic              pie_q;
    logic              cfg_change;

    assign cfg_change = (rate_sel != rate_q) || (div_sel != div_q) || (pie != pie_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_ok) state_d = ST_LOAD;
            ST_LOAD:  state_d = run_ok ? ST_COUNT : ST_IDLE;
            ST_COUNT: begin
                if (!run_ok)         state_d = ST_IDLE;
                else if (cfg_change) state_d = ST_LOAD;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        expire = (state_q == ST_COUNT) && run_ok && !cfg_change &&
                 tick_32k && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rate_q <= '0;
            div_q  <= '0;
            pie_q  <= 1'b0;
        end else begin
            rate_q <= rate_sel;
            div_q  <= div_sel;
            pie_q  <= pie;
            if (state_q != ST_COUNT || cfg_change || !run_ok)
                cnt_q <= '0;
            else if (tick_32k)
                cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rpi_flags.sv
module rpi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rd_c,
    input  logic pie,
    output logic pf_flag,
    output logic irqf_flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_flag   <= 1'b0;
            irqf_flag <= 1'b0;
        end else if (expire) begin
            pf_flag   <= 1'b1;
            irqf_flag <= 1'b1;
        end else if (rd_c) begin
            pf_flag   <= 1'b0;
            irqf_flag <= 1'b0;
        end
    end

    assign irq = irqf_flag && pie;
endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
    import rpi_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie,
    input  logic              rd_c,
    output logic              pf_flag,
    output logic              irqf_flag,
    output logic              irq
);
    localparam int CNT_W = (2 ** RATE_W) - 1;

    logic             run_ok;
    logic [CNT_W-1:0] last_cnt;
    logic             expire;

    rpi_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_dec (
        .div_sel  (div_sel),
        .rate_sel (rate_sel),
        .run_ok   (run_ok),
        .last_cnt (last_cnt)
    );

    rpi_period_ctr #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_32k (tick_32k),
        .div_sel  (div_sel),
        .rate_sel (rate_sel),
        .pie      (pie),
        .run_ok   (run_ok),
        .last_cnt (last_cnt),
        .expire   (expire)
    );

    rpi_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .rd_c      (rd_c),
        .pie       (pie),
        .pf_flag   (pf_flag),
        .irqf_flag (irqf_flag),
        .irq       (irq)
    );
endmodule

// File: rtl/rpi_checker.sv
module rpi_checker
    import rpi_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_32k,
    input logic [DIV_W-1:0]  div_sel,
    input logic [RATE_W-1:0] rate_sel,
    input logic              pie,
    input logic              rd_c,
    input logic              pf_flag,
    input logic              irqf_flag,
    input logic              irq
);
    logic bad_ref;
    assign bad_ref = !((div_sel == REF_4M) || (div_sel == REF_1M) || (div_sel == REF_32K));

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !tick_32k) |=> (!pf_flag && !irqf_flag));

    assert_flag_after_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_flag) |-> $past(tick_32k));

    assert_code_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !$rose(pf_flag));

    assert_bad_ref_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ref |=> !$rose(pf_flag));

    assert_flags_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_flag) |-> irqf_flag);

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pie && irqf_flag));
endmodule

bind rtc_periodic_irq rpi_checker #(.RATE_W(RATE_W)) u_rpi_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_32k  (tick_32k),
    .div_sel   (div_sel),
    .rate_sel  (rate_sel),
    .pie       (pie),
    .rd_c      (rd_c),
    .pf_flag   (pf_flag),
    .irqf_flag (irqf_flag),
    .irq       (irq)
);

// File: tb/tb_rtc_periodic_irq.sv
module tb_rtc_periodic_irq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [2:0] div_sel = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       pie = 1'b0;
    logic       rd_c = 1'b0;
    logic       pf_flag, irqf_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    exp_q[$];
    string tag_q[$];
    int    got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_periodic_irq dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .div_sel(div_sel),
        .rate_sel(rate_sel), .pie(pie), .rd_c(rd_c),
        .pf_flag(pf_flag), .irqf_flag(irqf_flag), .irq(irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with measured results
    always @(negedge clk) begin
        while (got_q.size() > 0 && exp_q.size() > 0)
            check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_32k = 1'b1; @(negedge clk);
            tick_32k = 1'b0; @(negedge clk);
        end
    endtask

    task automatic read_c();
        rd_c = 1'b1; @(negedge clk);
        rd_c = 1'b0;
    endtask

    // driver: push expected period, then count ticks until the flag rises
    task automatic measure(string tag, int exp_ticks, int limit);
        int n;
        exp_q.push_back(exp_ticks);
        tag_q.push_back(tag);
        idle(3);
        read_c();
        n = 0;
        while (!pf_flag && n < limit) begin
            pulse_ticks(1);
            n++;
        end
        got_q.push_back(pf_flag ? n : -1);
        @(negedge clk);
    endtask

    task automatic config_set(logic [2:0] d, logic [3:0] r, logic p);
        div_sel = d; rate_sel = r; pie = p;
        @(negedge clk);
    endtask

    initial begin
        idle(2);
        check("R1 pf after reset", pf_flag, 0);
        check("R1 irqf after reset", irqf_flag, 0);
        check("R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        idle(2);

        config_set(3'b000, 4'd3, 1'b1);
        measure("R2 R6 ref 000 code 3", 4, 1000);
        check("R6 irqf set with pf", irqf_flag, 1);
        config_set(3'b001, 4'd1, 1'b1);
        measure("R2 ref 001 code 1", 1, 1000);
        config_set(3'b000, 4'd6, 1'b1);
        measure("R2 ref 000 code 6", 32, 1000);
        config_set(3'b010, 4'd1, 1'b1);
        measure("R3 32k code 1", 128, 1000);
        config_set(3'b010, 4'd2, 1'b1);
        measure("R3 32k code 2", 256, 1000);
        config_set(3'b010, 4'd3, 1'b1);
        measure("R3 32k code 3 unmapped", 4, 1000);

        // R11 read clears
        check("R7 irq while enabled", irq, 1);
        read_c();
        check("R11 pf cleared", pf_flag, 0);
        check("R11 irqf cleared", irqf_flag, 0);
        check("R11 irq dropped", irq, 0);

        // R4 code zero
        config_set(3'b000, 4'd0, 1'b1);
        idle(3); read_c();
        pulse_ticks(600);
        check("R4 no flag with code 0", pf_flag, 0);

        // R5 invalid ref idles, then clears counter
        config_set(3'b110, 4'd3, 1'b1);
        idle(3); read_c();
        pulse_ticks(20);
        check("R5 no flag with bad ref", pf_flag, 0);
        config_set(3'b000, 4'd4, 1'b1);
        idle(3);
        pulse_ticks(5);
        config_set(3'b111, 4'd4, 1'b1);
        config_set(3'b000, 4'd4, 1'b1);
        measure("R5 full period after bad ref", 8, 1000);

        // R10 rate change mid period
        config_set(3'b000, 4'd4, 1'b1);
        idle(3); read_c();
        pulse_ticks(5);
        config_set(3'b000, 4'd3, 1'b1);
        measure("R10 reload on rate change", 4, 1000);

        // R9 enable toggle restarts
        config_set(3'b000, 4'd4, 1'b1);
        idle(3); read_c();
        pulse_ticks(5);
        config_set(3'b000, 4'd4, 1'b0);
        config_set(3'b000, 4'd4, 1'b1);
        measure("R9 restart on enable toggle", 8, 1000);

        // R7 disabled: flags set, line low
        config_set(3'b000, 4'd3, 1'b0);
        measure("R7 period with enable low", 4, 1000);
        check("R7 irqf set while disabled", irqf_flag, 1);
        check("R7 irq low while disabled", irq, 0);

        // R8 enable with pending flag
        pie = 1'b1; #1;
        check("R8 irq immediate on enable", irq, 1);
        @(negedge clk);

        // R12 no ticks, no advance
        config_set(3'b001, 4'd1, 1'b1);
        idle(3); read_c();
        idle(40);
        check("R12 no flag without ticks", pf_flag, 0);

        // R11 expiry in same cycle as read keeps flags
        tick_32k = 1'b1; rd_c = 1'b1; @(negedge clk);
        tick_32k = 1'b0; rd_c = 1'b0;
        check("R11 expiry beats read", pf_flag, 1);

        idle(4);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule